// File: doc/BRIEF.md
# Per-Queue Packet Ready Tracker

This block keeps a count of whole packets held in each of eight queues of a multi-queue buffer that runs in packet mode. A word written with its end-of-packet marker set adds one to the count of the queue it was written to. A word read with its end-of-packet marker set removes one from the count of the queue it was read from. The block does not store data and does not handle the timing of queue switches. It only tracks how many complete packets each queue holds.

Two signals come from these counts. An active-low ready flag reports the queue currently selected for reading. A read gate shuts that queue to readers until a whole packet has arrived, whatever the read enable does. A per-queue ready bus reports status in one of two ways. In direct mode it shows all eight queues at once. In polled mode a rotating pointer shows one queue per cycle on bit 0. Packet mode and bus mode are both taken from configuration inputs while reset is held, and they stay fixed until the next reset.

Top module: `pkt_ready_tracker`

## Requirements
- R1: The packet mode (cfg_pkt_mode high) and the bus mode (cfg_flag_mode low = direct, high = polled) are captured on every clock while rst_n is low and held once reset ends. Changes to either input after reset have no effect.
- R2: In packet mode, wr_en high with wr_eop high adds one to the count of queue wr_q. The change is visible from the cycle after the clock edge.
- R3: In packet mode, an allowed read (rd_en high, rd_gate high) with rd_eop high removes one from the count of queue rd_q. An end-marker write and an allowed end-marker read to the same queue in the same cycle leave its count unchanged.
- R4: pkt_rdy_n is low exactly when the mode is packet mode and queue rd_q holds at least one whole packet. Otherwise it is high.
- R5: In packet mode, rd_gate is low while queue rd_q holds no whole packet. A read attempted while the gate is low does not change any count.
- R6: Each count saturates at 2^CNT_W-1 (15 by default). End-marker writes to a full count are ignored.
- R7: eop_underflow is high for one cycle after a packet-mode cycle with rd_en and rd_eop high while queue rd_q holds no packet. The count stays at zero.
- R8: In direct mode, pkt_rdy_bus_n[i] is low exactly when queue i holds at least one packet, and poll_q stays 0.
- R9: In polled mode, poll_q is 0 during reset and steps by one each clock, wrapping from 7 to 0. pkt_rdy_bus_n[0] shows the ready state (low = ready) of queue poll_q. Bits 7:1 are high.
- R10: pkt_avail is high exactly when pkt_rdy_n is low and ov_n is low.
- R11: Outside packet mode, pkt_rdy_n and every bus bit are high, rd_gate is high, eop_underflow stays low, and no count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_pkt_mode | input | 1 | High selects packet mode at reset |
| cfg_flag_mode | input | 1 | Low selects direct bus, high selects polled bus, at reset |
| wr_en | input | 1 | A word is written this cycle |
| wr_q | input | 3 | Queue being written |
| wr_eop | input | 1 | End-of-packet marker of the written word |
| rd_en | input | 1 | A read of queue rd_q is requested |
| rd_q | input | 3 | Queue selected on the read side |
| rd_eop | input | 1 | End-of-packet marker of the word being read |
| ov_n | input | 1 | Active-low output-valid from the data path |
| pkt_rdy_n | output | 1 | Active-low packet ready for queue rd_q |
| pkt_rdy_bus_n | output | 8 | Active-low per-queue ready bus (direct or polled) |
| poll_q | output | 3 | Queue shown on bus bit 0 in polled mode |
| rd_gate | output | 1 | High when a read of queue rd_q may proceed |
| pkt_avail | output | 1 | A complete packet is ready and output data is valid |
| eop_underflow | output | 1 | An end marker was read from an empty count |

## Verification
A count that is off by one stays hidden until its queue is drained. It then shows up at the ports as pkt_rdy_n or rd_gate changing state one packet too early or too late. This happens in the cycle right after the edge that moves the count. A broken mode latch, a stuck poll pointer or a wrong bus bit shows up within one cycle after reset ends, or within eight cycles when the pointer sweeps all queues. Saturation and underflow errors appear only at the ends of the count range, so the bench drives one queue to its full value and then drains it to zero.

// File: rtl/prt_pkg.sv
// Package: shared sizes for the packet ready tracker.
// Assumes the queue count is a power of two, so the index fits QW bits exactly.
package prt_pkg;
    localparam int NQ    = 8;            // number of queues
    localparam int QW    = $clog2(NQ);   // queue index width
    localparam int CNT_W = 4;            // per-queue packet count width

    // Bus reporting style captured at reset
    typedef enum logic {
        BUS_DIRECT = 1'b0,
        BUS_POLLED = 1'b1
    } bus_mode_e;
endpackage

// File: rtl/prt_mode_ctrl.sv
// prt_mode_ctrl: captures the packet/bus modes while reset is low and runs the
// polled-mode pointer. Assumes synchronous active-low reset and NQ >= 2.
module prt_mode_ctrl
    import prt_pkg::*;
#(
    parameter int N_Q = NQ,
    localparam int Q_W = $clog2(N_Q)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_pkt_mode,
    input  logic           cfg_flag_mode,
    output logic           mode_pkt,
    output bus_mode_e      bus_mode,
    output logic [Q_W-1:0] poll_ptr
);
    localparam logic [Q_W-1:0] PTR_LAST = Q_W'(N_Q - 1);

    // Capture the configuration on each reset cycle and hold it afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_pkt <= cfg_pkt_mode;
            bus_mode <= bus_mode_e'(cfg_flag_mode);
        end
    end

    // Step the polled-mode pointer through every queue in turn
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_ptr <= '0;
        end else if (mode_pkt && bus_mode == BUS_POLLED) begin
            poll_ptr <= (poll_ptr == PTR_LAST) ? '0 : poll_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/prt_queue_counter.sv
// prt_queue_counter: complete-packet count for one queue. inc and dec come
// from the top already qualified. dec is raised only while the count is
// nonzero. The count saturates at its top value.
module prt_queue_counter #(
    parameter int C_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           inc,
    input  logic           dec,
    output logic [C_W-1:0] count,
    output logic           nonzero
);
    localparam logic [C_W-1:0] CNT_MAX = '1;

    // Apply one step up or down; a step both ways at once leaves the count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && !dec && count != CNT_MAX) begin
            count <= count + 1'b1;
        end else if (dec && !inc && count != '0) begin
            count <= count - 1'b1;
        end
    end

    // Report whether at least one whole packet is present
    always_comb nonzero = (count != '0);
endmodule

// File: rtl/prt_flag_view.sv
// prt_flag_view: forms the ready flag, the read gate and the ready bus from the
// per-queue nonzero vector. Purely combinational.
module prt_flag_view
    import prt_pkg::*;
#(
    parameter int N_Q = NQ,
    localparam int Q_W = $clog2(N_Q)
) (
    input  logic [N_Q-1:0] q_nonzero,
    input  logic [Q_W-1:0] sel_q,
    input  logic [Q_W-1:0] poll_ptr,
    input  logic           mode_pkt,
    input  bus_mode_e      bus_mode,
    output logic           rdy_n,
    output logic           gate,
    output logic [N_Q-1:0] bus_n
);
    // Ready flag and gate for the queue selected on the read side
    always_comb begin
        rdy_n = !(mode_pkt && q_nonzero[sel_q]);
        gate  = !mode_pkt || q_nonzero[sel_q];
    end

    // Ready bus: all queues in direct mode, one rotating queue in polled mode
    always_comb begin
        bus_n = '1;
        if (mode_pkt) begin
            if (bus_mode == BUS_DIRECT) begin
                bus_n = ~q_nonzero;
            end else begin
                bus_n[0] = !q_nonzero[poll_ptr];
            end
        end
    end
endmodule

// File: rtl/pkt_ready_tracker.sv
// pkt_ready_tracker: per-queue complete-packet tracker. Counts end-of-packet
// words written and read for each queue, flags packet readiness for the read
// queue, gates reads until a whole packet exists, and reports on a bus.
// Assumes one clock for both ports and that the data path honours rd_gate.
module pkt_ready_tracker
    import prt_pkg::*;
#(
    parameter int N_Q = NQ,
    parameter int C_W = CNT_W,
    localparam int Q_W = $clog2(N_Q)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_pkt_mode,
    input  logic           cfg_flag_mode,
    input  logic           wr_en,
    input  logic [Q_W-1:0] wr_q,
    input  logic           wr_eop,
    input  logic           rd_en,
    input  logic [Q_W-1:0] rd_q,
    input  logic           rd_eop,
    input  logic           ov_n,
    output logic           pkt_rdy_n,
    output logic [N_Q-1:0] pkt_rdy_bus_n,
    output logic [Q_W-1:0] poll_q,
    output logic           rd_gate,
    output logic           pkt_avail,
    output logic           eop_underflow
);
    logic             mode_pkt;
    bus_mode_e        bus_mode;
    logic [Q_W-1:0]   poll_ptr;
    logic [N_Q-1:0]   q_nonzero;
    logic [N_Q-1:0]   q_inc;
    logic [N_Q-1:0]   q_dec;
    logic [C_W-1:0]   q_count [N_Q];
    logic             rd_take_eop;

    prt_mode_ctrl #(.N_Q(N_Q)) u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_pkt_mode  (cfg_pkt_mode),
        .cfg_flag_mode (cfg_flag_mode),
        .mode_pkt      (mode_pkt),
        .bus_mode      (bus_mode),
        .poll_ptr      (poll_ptr)
    );

    // An end-marker read counts only when the gate lets the read through
    always_comb rd_take_eop = mode_pkt && rd_en && rd_eop && rd_gate;

    // Decode write and read end markers into per-queue step requests
    always_comb begin
        q_inc = '0;
        q_dec = '0;
        if (mode_pkt && wr_en && wr_eop) q_inc[wr_q] = 1'b1;
        if (rd_take_eop)                 q_dec[rd_q] = 1'b1;
    end

    generate
        for (genvar gi = 0; gi < N_Q; gi++) begin : g_q
            prt_queue_counter #(.C_W(C_W)) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .inc     (q_inc[gi]),
                .dec     (q_dec[gi]),
                .count   (q_count[gi]),
                .nonzero (q_nonzero[gi])
            );
        end
    endgenerate

    prt_flag_view #(.N_Q(N_Q)) u_view (
        .q_nonzero (q_nonzero),
        .sel_q     (rd_q),
        .poll_ptr  (poll_ptr),
        .mode_pkt  (mode_pkt),
        .bus_mode  (bus_mode),
        .rdy_n     (pkt_rdy_n),
        .gate      (rd_gate),
        .bus_n     (pkt_rdy_bus_n)
    );

    // Flag an end marker read from a queue whose count is zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eop_underflow <= 1'b0;
        end else begin
            eop_underflow <= mode_pkt && rd_en && rd_eop && !q_nonzero[rd_q];
        end
    end

    // Packet usable only when ready and the data path has valid output
    always_comb pkt_avail = !pkt_rdy_n && !ov_n;
    always_comb poll_q = poll_ptr;
endmodule

// File: rtl/prt_checker.sv
// prt_checker: temporal properties of the tracker, bound into the top module.
module prt_checker
    import prt_pkg::*;
#(
    parameter int N_Q = NQ,
    localparam int Q_W = $clog2(N_Q)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rd_en,
    input logic [Q_W-1:0] rd_q,
    input logic           rd_eop,
    input logic           ov_n,
    input logic           pkt_rdy_n,
    input logic [N_Q-1:0] pkt_rdy_bus_n,
    input logic [Q_W-1:0] poll_q,
    input logic           rd_gate,
    input logic           pkt_avail,
    input logic           eop_underflow,
    input logic           mode_pkt,
    input bus_mode_e      bus_mode
);
    localparam logic [Q_W-1:0] LAST_Q = Q_W'(N_Q - 1);

    // R1: the captured modes never move outside reset
    assert_mode_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(mode_pkt) && $stable(bus_mode)));

    // R5: a closed gate always goes with a not-ready flag in packet mode
    assert_gate_closed_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_pkt && !rd_gate) |-> pkt_rdy_n);

    // R7: an underflow report needs an end-marker read from an empty queue
    assert_underflow_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_underflow && $past(rst_n)) |-> $past(rd_en && rd_eop && pkt_rdy_n && mode_pkt));

    // R8: in direct mode the bus bit of the read queue matches the flag
    assert_direct_bus_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_pkt && bus_mode == BUS_DIRECT) |-> (pkt_rdy_bus_n[rd_q] == pkt_rdy_n && poll_q == '0));

    // R9: the poll pointer advances by one per cycle and wraps
    assert_poll_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_pkt && bus_mode == BUS_POLLED) |->
            (poll_q == (($past(poll_q) == LAST_Q) ? '0 : $past(poll_q) + 1'b1)));

    // R10: packet available only with ready and valid output
    assert_avail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_avail |-> (!pkt_rdy_n && !ov_n));

    // R11: outside packet mode nothing is flagged and reads pass
    assert_passthrough_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_pkt |-> (pkt_rdy_n && rd_gate && (&pkt_rdy_bus_n) && !eop_underflow));
endmodule

bind pkt_ready_tracker prt_checker #(.N_Q(N_Q)) u_prt_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_en         (rd_en),
    .rd_q          (rd_q),
    .rd_eop        (rd_eop),
    .ov_n          (ov_n),
    .pkt_rdy_n     (pkt_rdy_n),
    .pkt_rdy_bus_n (pkt_rdy_bus_n),
    .poll_q        (poll_q),
    .rd_gate       (rd_gate),
    .pkt_avail     (pkt_avail),
    .eop_underflow (eop_underflow),
    .mode_pkt      (mode_pkt),
    .bus_mode      (bus_mode)
);

// File: tb/pkt_ready_tracker_tb.sv
// Bench: one table-driven walk in direct packet mode, then directed tests.
module pkt_ready_tracker_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_pkt_mode = 1'b1, cfg_flag_mode = 1'b0;
    logic       wr_en = 1'b0, wr_eop = 1'b0, rd_en = 1'b0, rd_eop = 1'b0, ov_n = 1'b1;
    logic [2:0] wr_q = '0, rd_q = '0;
    logic       pkt_rdy_n, rd_gate, pkt_avail, eop_underflow;
    logic [7:0] pkt_rdy_bus_n;
    logic [2:0] poll_q;
    int         n_chk = 0, n_err = 0;

    always #5 clk = ~clk;

    pkt_ready_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_pkt_mode(cfg_pkt_mode), .cfg_flag_mode(cfg_flag_mode),
        .wr_en(wr_en), .wr_q(wr_q), .wr_eop(wr_eop), .rd_en(rd_en), .rd_q(rd_q),
        .rd_eop(rd_eop), .ov_n(ov_n), .pkt_rdy_n(pkt_rdy_n), .pkt_rdy_bus_n(pkt_rdy_bus_n),
        .poll_q(poll_q), .rd_gate(rd_gate), .pkt_avail(pkt_avail), .eop_underflow(eop_underflow)
    );

    // {wen,wq,weop, ren,rq,reop, exp_rdy_n, exp_gate, exp_bus, exp_err}
    localparam logic [20:0] VEC [12] = '{
        {1'b1,3'd0,1'b0, 1'b0,3'd0,1'b0, 1'b1,1'b0, 8'hFF, 1'b0},
        {1'b1,3'd0,1'b1, 1'b0,3'd0,1'b0, 1'b0,1'b1, 8'hFE, 1'b0},
        {1'b1,3'd3,1'b1, 1'b0,3'd3,1'b0, 1'b0,1'b1, 8'hF6, 1'b0},
        {1'b0,3'd0,1'b0, 1'b1,3'd0,1'b1, 1'b1,1'b0, 8'hF7, 1'b0},
        {1'b1,3'd3,1'b1, 1'b1,3'd3,1'b1, 1'b0,1'b1, 8'hF7, 1'b0},
        {1'b0,3'd0,1'b0, 1'b1,3'd3,1'b0, 1'b0,1'b1, 8'hF7, 1'b0},
        {1'b0,3'd0,1'b0, 1'b1,3'd3,1'b1, 1'b1,1'b0, 8'hFF, 1'b0},
        {1'b1,3'd7,1'b1, 1'b0,3'd5,1'b0, 1'b1,1'b0, 8'h7F, 1'b0},
        {1'b0,3'd0,1'b0, 1'b0,3'd7,1'b0, 1'b0,1'b1, 8'h7F, 1'b0},
        {1'b1,3'd7,1'b0, 1'b1,3'd7,1'b1, 1'b1,1'b0, 8'hFF, 1'b0},
        {1'b0,3'd0,1'b0, 1'b1,3'd2,1'b1, 1'b1,1'b0, 8'hFF, 1'b1},
        {1'b0,3'd0,1'b0, 1'b0,3'd0,1'b0, 1'b1,1'b0, 8'hFF, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic pkt, input logic fm);
        @(negedge clk);
        rst_n = 1'b0; cfg_pkt_mode = pkt; cfg_flag_mode = fm;
        wr_en = 1'b0; rd_en = 1'b0; wr_eop = 1'b0; rd_eop = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Apply one cycle of stimulus at a falling edge; leave at the next one
    task automatic cyc(input logic we, input logic [2:0] wq, input logic weop,
                       input logic re, input logic [2:0] rq, input logic reop);
        wr_en = we; wr_q = wq; wr_eop = weop; rd_en = re; rd_q = rq; rd_eop = reop;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; wr_eop = 1'b0; rd_eop = 1'b0;
    endtask

    initial begin
        #1500000;
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // Reset state, direct packet mode (R4 R5 R8)
        do_reset(1'b1, 1'b0);
        check("R4 reset flag", {7'd0, pkt_rdy_n}, 8'd1);
        check("R5 reset gate", {7'd0, rd_gate}, 8'd0);
        check("R8 reset bus", pkt_rdy_bus_n, 8'hFF);
        check("R7 reset err", {7'd0, eop_underflow}, 8'd0);

        // Table walk: R2 R3 R4 R5 R7 R8
        foreach (VEC[i]) begin
            cyc(VEC[i][20], VEC[i][19:17], VEC[i][16], VEC[i][15], VEC[i][14:12], VEC[i][11]);
            check("R2/R3 vec flag", {7'd0, pkt_rdy_n}, {7'd0, VEC[i][10]});
            check("R5 vec gate", {7'd0, rd_gate}, {7'd0, VEC[i][9]});
            check("R8 vec bus", pkt_rdy_bus_n, VEC[i][8:1]);
            check("R7 vec err", {7'd0, eop_underflow}, {7'd0, VEC[i][0]});
        end

        // R5: blocked read of queue 6 leaves it empty, then a write makes it ready
        cyc(1'b0, 3'd0, 1'b0, 1'b1, 3'd6, 1'b0);
        check("R5 blocked read", {7'd0, rd_gate}, 8'd0);
        cyc(1'b1, 3'd6, 1'b1, 1'b0, 3'd6, 1'b0);
        check("R2 after write", {7'd0, pkt_rdy_n}, 8'd0);

        // R10: availability follows output-valid
        ov_n = 1'b1; #1;
        check("R10 ov high", {7'd0, pkt_avail}, 8'd0);
        ov_n = 1'b0; #1;
        check("R10 ov low", {7'd0, pkt_avail}, 8'd1);
        ov_n = 1'b1;

        // R6: saturate queue 1 with 17 end markers, drain 15
        for (int k = 0; k < 17; k++) cyc(1'b1, 3'd1, 1'b1, 1'b0, 3'd1, 1'b0);
        for (int k = 0; k < 14; k++) cyc(1'b0, 3'd0, 1'b0, 1'b1, 3'd1, 1'b1);
        check("R6 one left", {7'd0, pkt_rdy_n}, 8'd0);
        cyc(1'b0, 3'd0, 1'b0, 1'b1, 3'd1, 1'b1);
        check("R6 drained", {7'd0, pkt_rdy_n}, 8'd1);
        check("R6 drained bus", {7'd0, pkt_rdy_bus_n[1]}, 8'd1);

        // R1: changing configuration after reset has no effect
        cfg_pkt_mode = 1'b0; cfg_flag_mode = 1'b1;
        cyc(1'b0, 3'd0, 1'b0, 1'b0, 3'd2, 1'b0);
        check("R1 gate held", {7'd0, rd_gate}, 8'd0);
        check("R1 poll held", {5'd0, poll_q}, 8'd0);

        // R9: polled mode with a packet in queue 4
        do_reset(1'b1, 1'b1);
        check("R9 first ptr", {5'd0, poll_q}, 8'd0);
        cyc(1'b1, 3'd4, 1'b1, 1'b0, 3'd0, 1'b0);
        for (int k = 0; k < 8; k++) begin
            check("R9 ptr", {5'd0, poll_q}, 8'((k + 1) % 8 + 1) - 8'd1 + 8'd0);
            check("R9 bit0", {7'd0, pkt_rdy_bus_n[0]}, {7'd0, (poll_q != 3'd4)});
            check("R9 upper", {1'b0, pkt_rdy_bus_n[7:1]}, 8'h7F);
            @(negedge clk);
        end

        // R11: non-packet mode ignores markers
        do_reset(1'b0, 1'b0);
        cyc(1'b1, 3'd2, 1'b1, 1'b0, 3'd2, 1'b0);
        check("R11 flag", {7'd0, pkt_rdy_n}, 8'd1);
        check("R11 gate", {7'd0, rd_gate}, 8'd1);
        check("R11 bus", pkt_rdy_bus_n, 8'hFF);
        cyc(1'b0, 3'd0, 1'b0, 1'b1, 3'd5, 1'b1);
        check("R11 no err", {7'd0, eop_underflow}, 8'd0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule